// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the control-store address of the next microinstruction on every clock. It holds the current control address and a single-entry return register. The sequencing fields of the microinstruction now executing come in from outside: a condition selector, a branch kind and a 7-bit target. Three status bits from the datapath and a 4-bit opcode also come in. From these the block picks one of four address sources. The sources are the incremented current address, the target field, the saved return address and an opcode-derived routine entry.

The block sits between a 128-word control store and its address port. The select and load strobes are combinational decodes of the current fields. They are also brought out so that the surrounding control logic can observe which source was taken. The address register updates on the rising clock edge.

The block has one address register, which acts as the state. The branch kind names four transitions out of any address:
- JUMP: go to the target when the test bit is set, otherwise step.
- CALL: go to the target and save the step address when the test bit is set, otherwise step.
- RETURN: go to the saved address.
- MAP: go to the opcode entry.

Reset places the register at the fetch entry, address 64.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, the address becomes 64 and the return register becomes 0. A RETURN issued right after reset therefore yields address 0.
- R2: `cond_sel` picks the test bit T as follows: 0 gives constant 1, 1 gives `ind_bit`, 2 gives `acc_sign`, 3 gives `acc_zero`.
- R3: With `br_kind` = 0 (JUMP), the next address is `jump_addr` when T=1 and the current address plus 1 when T=0.
- R4: With `br_kind` = 1 (CALL) and T=1, the next address is `jump_addr` and the return register takes the current address plus 1. With T=0, the address steps by 1 and the return register keeps its value.
- R5: With `br_kind` = 2 (RETURN), the next address is the return register content, whatever T is.
- R6: With `br_kind` = 3 (MAP), the next address has bit 6 = 0, bits 5..2 = `opcode[3:0]` and bits 1..0 = 0.
- R7: `src_sel` encodes the source: 0 is step, 1 is target field, 2 is return register, 3 is opcode map. Its value is {b1, b1&b0 | ~b1&T}, where b1b0 is `br_kind`.
- R8: `ret_load` is high exactly when `br_kind` = 1 and T = 1.
- R9: Stepping from address 127 gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_sel | input | 2 | Test-bit selector of the current microinstruction |
| br_kind | input | 2 | Branch kind of the current microinstruction |
| jump_addr | input | 7 | Target address field |
| ind_bit | input | 1 | Indirect flag from the data register |
| acc_sign | input | 1 | Accumulator sign |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| opcode | input | 4 | Machine opcode used by MAP |
| car_q | output | 7 | Current control-store address |
| src_sel | output | 2 | Chosen next-address source |
| ret_load | output | 1 | Return register load strobe |

## Verification
The return register cannot be seen at the ports. Its content only shows up when a RETURN executes. The stimulus therefore checks a not-taken CALL followed by a RETURN, to prove that the saved value survived. It also checks a RETURN right after reset, and a taken CALL at address 127, where the saved step address must wrap to 0. The test bit is likewise hidden. Every combination of selector and wanted T value is produced by forcing only the selected status bit and randomising the other two.

// File: rtl/useq_pkg.sv
package useq_pkg;
    parameter int ADDR_W    = 7;
    parameter int OP_W      = 4;
    parameter int FETCH_ORG = 64;

    typedef enum logic [1:0] {
        BR_JUMP   = 2'b00,
        BR_CALL   = 2'b01,
        BR_RETURN = 2'b10,
        BR_MAP    = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_STEP   = 2'b00,
        SRC_FIELD  = 2'b01,
        SRC_RETREG = 2'b10,
        SRC_OPMAP  = 2'b11
    } src_e;

    typedef enum logic [1:0] {
        CND_ALWAYS   = 2'b00,
        CND_INDIRECT = 2'b01,
        CND_SIGN     = 2'b10,
        CND_ZERO     = 2'b11
    } cond_e;
endpackage

// File: rtl/useq_test_pick.sv
module useq_test_pick
    import useq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_zero,
    output logic       t_bit
);
    cond_e sel_e;
    assign sel_e = cond_e'(cond_sel);

    always_comb begin
        unique case (sel_e)
            CND_ALWAYS:   t_bit = 1'b1;
            CND_INDIRECT: t_bit = ind_bit;
            CND_SIGN:     t_bit = acc_sign;
            CND_ZERO:     t_bit = acc_zero;
            default:      t_bit = 1'b1;
        endcase
    end
endmodule

// File: rtl/useq_select_logic.sv
module useq_select_logic
    import useq_pkg::*;
(
    input  logic [1:0] br_kind,
    input  logic       t_bit,
    output logic [1:0] src_sel,
    output logic       ret_load
);
    br_kind_e kind_e;
    src_e     src_v;
    assign kind_e = br_kind_e'(br_kind);

    always_comb begin
        unique case (kind_e)
            BR_JUMP:   src_v = t_bit ? SRC_FIELD : SRC_STEP;
            BR_CALL:   src_v = t_bit ? SRC_FIELD : SRC_STEP;
            BR_RETURN: src_v = SRC_RETREG;
            BR_MAP:    src_v = SRC_OPMAP;
            default:   src_v = SRC_STEP;
        endcase
    end

    assign src_sel  = src_v;
    assign ret_load = (kind_e == BR_CALL) && t_bit;
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
    import useq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OP_W
) (
    input  logic [1:0]    src_sel,
    input  logic [AW-1:0] car,
    input  logic [AW-1:0] field,
    input  logic [AW-1:0] retreg,
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] step,
    output logic [AW-1:0] next_addr
);
    localparam int MAP_LSB = 2;
    localparam int MAP_PAD = AW - OW - MAP_LSB;

    logic [AW-1:0] mapped;

    generate
        if (MAP_PAD > 0) begin : g_pad
            assign mapped = {{MAP_PAD{1'b0}}, opcode, {MAP_LSB{1'b0}}};
        end else begin : g_nopad
            assign mapped = {opcode[AW-MAP_LSB-1:0], {MAP_LSB{1'b0}}};
        end
    endgenerate

    assign step = car + AW'(1);

    src_e sel_e;
    assign sel_e = src_e'(src_sel);

    always_comb begin
        unique case (sel_e)
            SRC_STEP:   next_addr = step;
            SRC_FIELD:  next_addr = field;
            SRC_RETREG: next_addr = retreg;
            SRC_OPMAP:  next_addr = mapped;
            default:    next_addr = step;
        endcase
    end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
    import useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cond_sel,
    input  logic [1:0] br_kind,
    input  logic [6:0] jump_addr,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_zero,
    input  logic [3:0] opcode,
    output logic [6:0] car_q,
    output logic [1:0] src_sel,
    output logic       ret_load
);
    logic [ADDR_W-1:0] car_r;
    logic [ADDR_W-1:0] sbr_r;
    logic [ADDR_W-1:0] step_w;
    logic [ADDR_W-1:0] next_w;
    logic              t_w;

    useq_test_pick u_pick (
        .cond_sel (cond_sel),
        .ind_bit  (ind_bit),
        .acc_sign (acc_sign),
        .acc_zero (acc_zero),
        .t_bit    (t_w)
    );

    useq_select_logic u_sel (
        .br_kind  (br_kind),
        .t_bit    (t_w),
        .src_sel  (src_sel),
        .ret_load (ret_load)
    );

    useq_addr_mux #(.AW(ADDR_W), .OW(OP_W)) u_mux (
        .src_sel   (src_sel),
        .car       (car_r),
        .field     (jump_addr),
        .retreg    (sbr_r),
        .opcode    (opcode),
        .step      (step_w),
        .next_addr (next_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            car_r <= ADDR_W'(FETCH_ORG);
            sbr_r <= '0;
        end else begin
            car_r <= next_w;
            if (ret_load) sbr_r <= step_w;
        end
    end

    assign car_q = car_r;
endmodule

// File: rtl/useq_checker.sv
module useq_checker (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cond_sel,
    input logic [1:0] br_kind,
    input logic [6:0] jump_addr,
    input logic [3:0] opcode,
    input logic [6:0] car_q,
    input logic [1:0] src_sel,
    input logic       ret_load
);
    AST_UNCOND_JUMP: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && cond_sel == 2'b00) |=> car_q == $past(jump_addr)); // R3
    AST_MAP_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11) |=> (car_q[6] == 1'b0 && car_q[1:0] == 2'b00 && car_q[5:2] == $past(opcode))); // R6
    AST_RETURN_SRC: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b10) |-> src_sel == 2'b10); // R7
    AST_LOAD_ON_CALL: assert property (@(posedge clk) disable iff (rst)
        ret_load |-> (br_kind == 2'b01 && src_sel == 2'b01)); // R8
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (src_sel == 2'b00 && car_q == 7'd127) |=> car_q == 7'd0); // R9
endmodule

bind useq_sequencer useq_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .cond_sel  (cond_sel),
    .br_kind   (br_kind),
    .jump_addr (jump_addr),
    .opcode    (opcode),
    .car_q     (car_q),
    .src_sel   (src_sel),
    .ret_load  (ret_load)
);

// File: tb/test_useq_sequencer.sv
module test_useq_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cond_sel = '0;
    logic [1:0] br_kind = '0;
    logic [6:0] jump_addr = '0;
    logic       ind_bit = 1'b0;
    logic       acc_sign = 1'b0;
    logic       acc_zero = 1'b0;
    logic [3:0] opcode = '0;
    logic [6:0] car_q;
    logic [1:0] src_sel;
    logic       ret_load;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [6:0] car;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    logic [6:0] m_car;
    logic [6:0] m_sbr;

    always #(CLK_PERIOD/2) clk = ~clk;

    useq_sequencer i_useq_sequencer (
        .clk(clk), .rst(rst), .cond_sel(cond_sel), .br_kind(br_kind),
        .jump_addr(jump_addr), .ind_bit(ind_bit), .acc_sign(acc_sign),
        .acc_zero(acc_zero), .opcode(opcode), .car_q(car_q),
        .src_sel(src_sel), .ret_load(ret_load)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares address after each edge with the queued expectation
    always @(posedge clk) begin
        #1;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            check(e.tag, int'(car_q), int'(e.car));
        end
    end

    // driver: applies one microinstruction, checks strobes, queues expected address
    task automatic step(input logic [1:0] cs, input logic [1:0] bk, input logic [6:0] ad,
                        input logic tval, input logic [3:0] op, input string tag);
        logic t;
        logic [1:0] sel;
        logic [6:0] nxt;
        exp_t e;
        @(negedge clk);
        cond_sel  = cs;
        br_kind   = bk;
        jump_addr = ad;
        opcode    = op;
        ind_bit   = (cs == 2'd1) ? tval : 1'($urandom);
        acc_sign  = (cs == 2'd2) ? tval : 1'($urandom);
        acc_zero  = (cs == 2'd3) ? tval : 1'($urandom);
        t = (cs == 2'd0) ? 1'b1 : tval;   // R2
        sel = {bk[1], (bk[1] & bk[0]) | (~bk[1] & t)};
        case (sel)
            2'd0: nxt = m_car + 7'd1;
            2'd1: nxt = ad;
            2'd2: nxt = m_sbr;
            default: nxt = {1'b0, op, 2'b00};
        endcase
        #1;
        check({tag, " R7 src_sel"}, int'(src_sel), int'(sel));
        check({tag, " R8 ret_load"}, int'(ret_load), int'(bk == 2'd1 && t));
        if (bk == 2'd1 && t) m_sbr = m_car + 7'd1;
        m_car = nxt;
        e.car = nxt;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset address", int'(car_q), 64);
        m_car = 7'd64;
        m_sbr = 7'd0;
        step(2'd0, 2'd2, 7'd55, 1'b0, 4'd0, "R1 return after reset");
        step(2'd0, 2'd0, 7'd20, 1'b1, 4'd0, "R3 unconditional jump");
        step(2'd1, 2'd0, 7'd90, 1'b0, 4'd0, "R2 R3 indirect clear steps");
        step(2'd2, 2'd0, 7'd90, 1'b1, 4'd0, "R2 R3 sign set jumps");
        step(2'd3, 2'd0, 7'd5,  1'b0, 4'd0, "R2 R3 zero clear steps");
        step(2'd3, 2'd1, 7'd70, 1'b1, 4'd0, "R4 call taken");
        step(2'd0, 2'd0, 7'd100, 1'b1, 4'd0, "R3 jump away");
        step(2'd1, 2'd1, 7'd33, 1'b0, 4'd0, "R4 call not taken");
        step(2'd2, 2'd2, 7'd12, 1'b0, 4'd0, "R5 return with T clear");
        step(2'd0, 2'd3, 7'd0,  1'b1, 4'hF, "R6 map opcode F");
        step(2'd0, 2'd3, 7'd0,  1'b1, 4'h5, "R6 map opcode 5");
        step(2'd0, 2'd0, 7'd127, 1'b1, 4'd0, "R3 jump to top");
        step(2'd1, 2'd0, 7'd40, 1'b0, 4'd0, "R9 step wraps to 0");
        step(2'd0, 2'd0, 7'd127, 1'b1, 4'd0, "R3 jump to top again");
        step(2'd0, 2'd1, 7'd9,  1'b1, 4'd0, "R4 call at top saves 0");
        step(2'd0, 2'd2, 7'd9,  1'b1, 4'd0, "R5 R9 return to wrapped 0");
        for (int n = 0; n < 12; n++) begin
            for (int k = 0; k < 32; k++) begin
                logic [1:0] bk;
                logic [1:0] cs;
                logic tv;
                string tg;
                bk = k[4:3];
                cs = k[2:1];
                tv = k[0];
                case (bk)
                    2'd0: tg = "R3 sweep";
                    2'd1: tg = "R4 sweep";
                    2'd2: tg = "R5 sweep";
                    default: tg = "R6 sweep";
                endcase
                step(cs, bk, 7'($urandom), tv, 4'($urandom), tg);
            end
        end
        @(negedge clk);
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule